// File: doc/BRIEF.md
# Lane Transmit Equalization Controller

This block sets the transmitter equalization of one serial lane at the higher data rates. A requester picks an operation with a 2-bit control input. It can apply a numbered preset, which the block turns into three cursor coefficients through an internal lookup. It can also apply a custom coefficient set, which arrives six bits at a time over three consecutive clock cycles.

Each candidate coefficient set passes through a query step that checks it against the driver's full-swing and low-frequency limits. A set that fails is dropped and the coefficients already in effect stay. Completion is marked by a one-cycle done pulse. The requester must then return control to idle before the block accepts another request.

The full-swing and low-frequency values are parameters and appear on constant outputs. A 3-bit debug port shows the controller state with fixed codes.

Top module: `lane_txeq_ctrl`

## Requirements
- R1: Control code 2'b01 starts a preset request and 2'b10 starts a custom request. Codes 2'b00 and 2'b11 start nothing: with 2'b11 held, the state stays IDLE and the active coefficients do not change.
- R2: A custom request runs COEFF for three cycles, then QUERY, then DONE. The coefficient bus is captured on the three COEFF cycles in turn as pre-cursor [5:0], main cursor [11:6] and post-cursor [17:12] of the 18-bit word.
- R3: A preset request runs PRESET, which latches the preset number, then REMAP, then QUERY, then DONE. With the default parameters, preset p gives the (pre, post) pairs P0 (0,9), P1 (0,6), P2 (0,7), P3 (0,4), P4 (0,0), P5 (3,0), P6 (4,0), P7 (3,7), P8 (4,4), P9 (5,0), P10 (0,12). In every case main = FS - pre - post.
- R4: Preset numbers 11 to 15 give the coefficients of the default preset 4.
- R5: While reset is low, and after it is released, the active coefficients equal default preset 4 (18'h00900 with FS=36), the state is IDLE and done is low.
- R6: Done is high only in the DONE state, for exactly one cycle, and the state returns to IDLE on the next cycle.
- R7: After a request completes, no new request starts until control has been 2'b00 for at least one cycle.
- R8: A candidate set is accepted only if pre+main+post equals FS, main >= pre+post+LF, and pre <= FS/4. The active coefficients change only at the QUERY-to-DONE step. A rejected set leaves them unchanged.
- R9: The full-swing output equals parameter FS (default 36) and the low-frequency output equals parameter LF (default 12) at all times.
- R10: The debug state codes are IDLE=0, PRESET=1, COEFF=2, REMAP=3, QUERY=4, DONE=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eq_ctrl | input | 2 | Operation select: idle, preset or custom |
| eq_preset | input | 4 | Preset number for a preset request |
| eq_coeff | input | 6 | Serial coefficient slice for a custom request |
| fs_out | output | 6 | Full-swing value of the driver |
| lf_out | output | 6 | Low-frequency value of the driver |
| coeff_active | output | 18 | Coefficients in effect {post, main, pre} |
| eq_done | output | 1 | One-cycle completion pulse |
| dbg_state | output | 3 | Controller state code |

## Verification
The hardest conditions to reach from the ports are the rejection paths in QUERY, because they show only as an output that does not change.

The stimulus sweeps a grid of custom sets that crosses each validity limit. Some sets miss the swing sum by one, some break the low-frequency margin, and some have a pre-cursor above FS/4. Valid sets are placed between them so that every rejection has a known prior value to compare against.

Holding control at a non-idle code after done is the second condition that is hard to reach, and the stimulus keeps it there for several cycles.

// File: rtl/lane_txeq_ctrl.sv
module lane_txeq_ctrl #(
  parameter logic [5:0] FS_VAL         = 6'd36,
  parameter logic [5:0] LF_VAL         = 6'd12,
  parameter logic [3:0] DEFAULT_PRESET = 4'd4,
  parameter int         NUM_PRESETS    = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  eq_ctrl,
  input  logic [3:0]  eq_preset,
  input  logic [5:0]  eq_coeff,
  output logic [5:0]  fs_out,
  output logic [5:0]  lf_out,
  output logic [17:0] coeff_active,
  output logic        eq_done,
  output logic [2:0]  dbg_state
);

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_PRESET = 3'd1,
    S_COEFF  = 3'd2,
    S_REMAP  = 3'd3,
    S_QUERY  = 3'd4,
    S_DONE   = 3'd5
  } state_t;

  localparam logic [1:0] CTRL_IDLE   = 2'b00;
  localparam logic [1:0] CTRL_PRESET = 2'b01;
  localparam logic [1:0] CTRL_CUSTOM = 2'b10;
  localparam logic [5:0] PRE_MAX     = FS_VAL >> 2;

  function automatic logic [11:0] preset_pp(input logic [3:0] p);
    case (p)
      4'd0:    preset_pp = {6'd0, 6'd9};
      4'd1:    preset_pp = {6'd0, 6'd6};
      4'd2:    preset_pp = {6'd0, 6'd7};
      4'd3:    preset_pp = {6'd0, 6'd4};
      4'd5:    preset_pp = {6'd3, 6'd0};
      4'd6:    preset_pp = {6'd4, 6'd0};
      4'd7:    preset_pp = {6'd3, 6'd7};
      4'd8:    preset_pp = {6'd4, 6'd4};
      4'd9:    preset_pp = {6'd5, 6'd0};
      4'd10:   preset_pp = {6'd0, 6'd12};
      default: preset_pp = {6'd0, 6'd0};
    endcase
  endfunction

  function automatic logic [17:0] remap(input logic [3:0] p);
    logic [3:0]  sel;
    logic [11:0] pp;
    sel = (int'(p) < NUM_PRESETS) ? p : DEFAULT_PRESET;
    pp  = preset_pp(sel);
    remap = {pp[5:0], FS_VAL - pp[11:6] - pp[5:0], pp[11:6]};
  endfunction

  state_t      state;
  logic [1:0]  slice_cnt;
  logic [3:0]  preset_q;
  logic [17:0] cand;
  logic        armed;

  logic [7:0] c_pre, c_main, c_post;
  logic       cand_ok;

  assign c_pre  = {2'b0, cand[5:0]};
  assign c_main = {2'b0, cand[11:6]};
  assign c_post = {2'b0, cand[17:12]};
  assign cand_ok = (c_pre + c_main + c_post == {2'b0, FS_VAL}) &&
                   (c_main >= c_pre + c_post + {2'b0, LF_VAL}) &&
                   (cand[5:0] <= PRE_MAX);

  assign fs_out    = FS_VAL;
  assign lf_out    = LF_VAL;
  assign eq_done   = (state == S_DONE);
  assign dbg_state = state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      slice_cnt    <= 2'd0;
      preset_q     <= DEFAULT_PRESET;
      cand         <= '0;
      armed        <= 1'b1;
      coeff_active <= remap(DEFAULT_PRESET);
    end else begin
      case (state)
        S_IDLE: begin
          if (eq_ctrl == CTRL_IDLE) armed <= 1'b1;
          if (armed && eq_ctrl == CTRL_PRESET) begin
            state <= S_PRESET;
            armed <= 1'b0;
          end else if (armed && eq_ctrl == CTRL_CUSTOM) begin
            state     <= S_COEFF;
            slice_cnt <= 2'd0;
            armed     <= 1'b0;
          end
        end
        S_PRESET: begin
          preset_q <= eq_preset;
          state    <= S_REMAP;
        end
        S_REMAP: begin
          cand  <= remap(preset_q);
          state <= S_QUERY;
        end
        S_COEFF: begin
          case (slice_cnt)
            2'd0:    cand[5:0]   <= eq_coeff;
            2'd1:    cand[11:6]  <= eq_coeff;
            default: cand[17:12] <= eq_coeff;
          endcase
          slice_cnt <= slice_cnt + 2'd1;
          if (slice_cnt == 2'd2) state <= S_QUERY;
        end
        S_QUERY: begin
          if (cand_ok) coeff_active <= cand;
          state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lane_txeq_ctrl_chk.sv
module lane_txeq_ctrl_chk #(
  parameter logic [5:0] FS_VAL = 6'd36,
  parameter logic [5:0] LF_VAL = 6'd12
) (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  eq_ctrl,
  input logic        eq_done,
  input logic [2:0]  dbg_state,
  input logic [17:0] coeff_active
);

  logic [7:0] a_pre, a_main, a_post;
  assign a_pre  = {2'b0, coeff_active[5:0]};
  assign a_main = {2'b0, coeff_active[11:6]};
  assign a_post = {2'b0, coeff_active[17:12]};

  a_r10_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_state <= 3'd5);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    eq_done |=> !eq_done && dbg_state == 3'd0);

  a_r6_done_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    eq_done == (dbg_state == 3'd5));

  a_r2_three_slices: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_state == 3'd0 && eq_ctrl == 2'b10) ##1 (dbg_state == 3'd2)
      |=> dbg_state == 3'd2 ##1 dbg_state == 3'd2 ##1 dbg_state == 3'd4);

  a_r3_preset_path: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_state == 3'd1 |=> dbg_state == 3'd3 ##1 dbg_state == 3'd4 ##1 dbg_state == 3'd5);

  a_r8_update_only_query: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_state != 3'd4 |=> $stable(coeff_active));

  a_r8_active_valid: assert property (@(posedge clk) disable iff (!rst_n)
    eq_done |-> (a_pre + a_main + a_post == {2'b0, FS_VAL}) &&
                (a_main >= a_pre + a_post + {2'b0, LF_VAL}));

  a_r1_reserved_code: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_state == 3'd0 && eq_ctrl == 2'b11) |=> dbg_state == 3'd0);

endmodule

bind lane_txeq_ctrl lane_txeq_ctrl_chk #(.FS_VAL(FS_VAL), .LF_VAL(LF_VAL)) chk_i (
  .clk(clk), .rst_n(rst_n), .eq_ctrl(eq_ctrl), .eq_done(eq_done),
  .dbg_state(dbg_state), .coeff_active(coeff_active)
);

// File: tb/lane_txeq_ctrl_tb_top.sv
`timescale 1ns/1ps
module lane_txeq_ctrl_tb_top;
  localparam int FS = 36;
  localparam int LF = 12;
  localparam logic [17:0] DEF_COEFF = {6'd0, 6'd36, 6'd0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  eq_ctrl = 2'b00;
  logic [3:0]  eq_preset = 4'd0;
  logic [5:0]  eq_coeff = 6'd0;
  logic [5:0]  fs_out, lf_out;
  logic [17:0] coeff_active;
  logic        eq_done;
  logic [2:0]  dbg_state;

  int n_cmp = 0;
  int n_bad = 0;
  logic [17:0] exp_act;

  always #2.5 clk = ~clk;

  lane_txeq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .eq_ctrl(eq_ctrl), .eq_preset(eq_preset),
    .eq_coeff(eq_coeff), .fs_out(fs_out), .lf_out(lf_out),
    .coeff_active(coeff_active), .eq_done(eq_done), .dbg_state(dbg_state)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit ok_set(input int pre, input int mn, input int post);
    return (pre + mn + post == FS) && (mn >= pre + post + LF) && (pre <= FS / 4);
  endfunction

  function automatic logic [17:0] preset_exp(input int p);
    int pre, post;
    int q = (p > 10) ? 4 : p;
    case (q)
      0: begin pre = 0; post = 9; end
      1: begin pre = 0; post = 6; end
      2: begin pre = 0; post = 7; end
      3: begin pre = 0; post = 4; end
      5: begin pre = 3; post = 0; end
      6: begin pre = 4; post = 0; end
      7: begin pre = 3; post = 7; end
      8: begin pre = 4; post = 4; end
      9: begin pre = 5; post = 0; end
      10: begin pre = 0; post = 12; end
      default: begin pre = 0; post = 0; end
    endcase
    return {6'(post), 6'(FS - pre - post), 6'(pre)};
  endfunction

  task automatic run_custom(input int pre, input int mn, input int post);
    @(negedge clk); eq_ctrl = 2'b10;
    @(negedge clk); chk("R2 state COEFF", dbg_state, 2); eq_coeff = 6'(pre);
    @(negedge clk); chk("R2 state COEFF", dbg_state, 2); eq_coeff = 6'(mn);
    @(negedge clk); chk("R2 state COEFF", dbg_state, 2); eq_coeff = 6'(post);
    @(negedge clk); chk("R2 state QUERY", dbg_state, 4);
    chk("R8 no early update", coeff_active, exp_act);
    @(negedge clk);
    if (ok_set(pre, mn, post)) exp_act = {6'(post), 6'(mn), 6'(pre)};
    chk("R6 done high", eq_done, 1);
    chk("R10 state DONE", dbg_state, 5);
    chk("R8 R2 active coeff", coeff_active, exp_act);
    eq_ctrl = 2'b00;
    @(negedge clk); chk("R6 done low after", eq_done, 0);
    chk("R6 back to IDLE", dbg_state, 0);
  endtask

  task automatic run_preset(input int p, input bit release_ctrl);
    @(negedge clk); eq_ctrl = 2'b01; eq_preset = 4'(p);
    @(negedge clk); chk("R3 state PRESET", dbg_state, 1);
    @(negedge clk); chk("R3 state REMAP", dbg_state, 3);
    @(negedge clk); chk("R3 state QUERY", dbg_state, 4);
    @(negedge clk);
    exp_act = preset_exp(p);
    chk("R6 done high", eq_done, 1);
    if (p > 10) chk("R4 out of range preset", coeff_active, exp_act);
    else        chk("R3 preset coeff", coeff_active, exp_act);
    if (release_ctrl) eq_ctrl = 2'b00;
    @(negedge clk); chk("R6 back to IDLE", dbg_state, 0);
  endtask

  initial begin
    #(5ns * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    exp_act = DEF_COEFF;
    repeat (3) @(negedge clk);
    chk("R5 reset coeff", coeff_active, DEF_COEFF);
    chk("R5 reset done", eq_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 idle after reset", dbg_state, 0);
    chk("R5 coeff after reset", coeff_active, DEF_COEFF);
    chk("R9 fs", fs_out, FS);
    chk("R9 lf", lf_out, LF);

    eq_ctrl = 2'b11;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1 reserved stays IDLE", dbg_state, 0);
      chk("R1 reserved keeps coeff", coeff_active, exp_act);
    end
    eq_ctrl = 2'b00;

    for (int p = 0; p < 16; p++) run_preset(p, 1'b1);

    run_preset(7, 1'b0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R7 no restart without idle", dbg_state, 0);
      chk("R7 done stays low", eq_done, 0);
    end
    eq_ctrl = 2'b00;
    @(negedge clk);
    run_preset(2, 1'b1);

    for (int pre = 0; pre <= 10; pre++)
      for (int post = 0; post <= 12; post += 3)
        for (int v = 0; v < 2; v++)
          run_custom(pre, FS - pre - post + v, post);

    run_custom(2, 22, 12);
    run_custom(1, 1, 1);

    rst_n = 1'b0;
    @(negedge clk);
    chk("R5 mid reset coeff", coeff_active, DEF_COEFF);
    chk("R5 mid reset state", dbg_state, 0);
    rst_n = 1'b1;
    exp_act = DEF_COEFF;
    chk("R9 fs held", fs_out, FS);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule